// File: doc/BRIEF.md
# External Interrupt Request Controller

This block watches three external interrupt pins and turns the conditions seen on them into an interrupt request toward a processor core. Each pin first passes through a two-flop synchronizer. A per-line detector then looks for the condition software has chosen for that line. Lines 0 and 1 can be sensed on a low level, on any change, on a falling edge or on a rising edge. Line 2 is sensed on edges only, and one select bit picks the direction.

An edge sets a pending flag for its line. A flag is set whether or not the line is enabled. A low-level line latches nothing: it requests service only while its pin stays low. A per-line enable gates the pending state into the request. When several lines request at once, the reported index follows fixed priority, with line 0 first. The core clears a flag by acknowledging the line it serves. Software can also clear a flag by writing 1 to its bit. All registers sit on a simple address, write-data and write-strobe bus with a combinational read port.

On line 2 the direction logic compares a direction-normalised level with its value on the previous cycle. Flipping the select can therefore look like an edge and set the flag. Software is expected to mask the line, change the select, clear the flag and then unmask it.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every sense bit, the line-2 select, every enable and every flag read as zero, and `irq_o` is low.
- R2: Register map. Address 0 holds the sense codes: bits 1:0 for line 0 and bits 3:2 for line 1. Address 1 bit 0 is the line-2 select. Address 2 bits 5, 6 and 7 enable lines 0, 1 and 2. Address 3 bits 5, 6 and 7 are the flags of lines 0, 1 and 2. Every other bit reads as zero.
- R3: For lines 0 and 1 the sense code 00 means low level, 01 means any change, 10 means falling edge and 11 means rising edge. An edge of the chosen kind sets the line's flag.
- R4: A line in low-level mode never sets its flag. It requests service while its synchronized pin is low and the line is enabled, and it stops requesting once the pin returns high.
- R5: Line 2 is edge-only. With its select at 0 a falling edge sets its flag, and with its select at 1 a rising edge sets it.
- R6: A detected edge sets the flag even when the line is disabled. A disabled line never drives the request.
- R7: A pin change made between clock edges shows up as a set flag and a raised request on the third rising clock edge after it, and not earlier.
- R8: Writing 1 to a flag bit at address 3 clears that flag. Writing 0 to a flag bit, or writing any bit outside 7:5, leaves the flags unchanged.
- R9: When `ack_i` is high, the flag of the line named by `ack_idx_i` clears on that clock edge. If the same line detects an edge in that cycle, the flag stays set.
- R10: `irq_o` is high exactly when some enabled line is pending or level-active. `irq_idx_o` names the lowest-numbered such line, and it is 0 when no line requests.
- R11: Changing the line-2 select while its pin is steady can set the line-2 flag. From falling to rising with the pin high, the flag is set one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_i | input | 3 | Asynchronous external interrupt pins, bit n is line n |
| ack_i | input | 1 | Service acknowledge from the core |
| ack_idx_i | input | 2 | Line being acknowledged |
| irq_o | output | 1 | Interrupt request |
| irq_idx_o | output | 2 | Index of the highest-priority requesting line |

## Verification
The acknowledge assertion assumes that `ack_idx_i` names one of the three lines whenever `ack_i` is high. The stimulus acknowledges only indices 0 to 2. The flag-clear and level-mode assertions assume that register writes are single-cycle strobes with stable address and data. The bench therefore changes bus inputs, pins and acknowledges only on falling clock edges. It holds pins steady for several cycles, so that every edge crosses the synchronizer as one clean transition.

// File: rtl/eirq_pkg.sv
package eirq_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_ANY  = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    localparam int unsigned REG_SENSE = 0;
    localparam int unsigned REG_SEL   = 1;
    localparam int unsigned REG_EN    = 2;
    localparam int unsigned REG_FLAG  = 3;

endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q_o      <= '0;
        end else begin
            stage1_q <= d_i;
            q_o      <= stage1_q;
        end
    end
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
    import eirq_pkg::*;
#(
    parameter bit DUAL_SENSE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl_i,
    input  logic [1:0] cfg_i,
    output logic       hit_o,
    output logic       low_o
);
    generate
        if (DUAL_SENSE) begin : g_dual
            logic prev_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= lvl_i;
            end

            always_comb begin
                unique case (sense_e'(cfg_i))
                    SNS_LOW:  hit_o = 1'b0;
                    SNS_ANY:  hit_o = lvl_i ^ prev_q;
                    SNS_FALL: hit_o = prev_q & ~lvl_i;
                    SNS_RISE: hit_o = ~prev_q & lvl_i;
                    default:  hit_o = 1'b0;
                endcase
            end

            assign low_o = (sense_e'(cfg_i) == SNS_LOW) && !lvl_i;
        end else begin : g_edge_only
            // Level normalised to the selected direction: the wanted edge
            // is always a rise of eff. A select flip can fake that rise.
            logic eff;
            logic eff_q;

            assign eff = (sense_e'(cfg_i) == SNS_RISE) ? lvl_i : ~lvl_i;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) eff_q <= 1'b1;
                else        eff_q <= eff;
            end

            assign hit_o = eff & ~eff_q;
            assign low_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/eirq_prio.sv
module eirq_prio #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import eirq_pkg::*;
#(
    parameter  int NUM_LINES = 3,
    parameter  int DATA_W    = 8,
    parameter  int ADDR_W    = 2,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0] pin_i,
    input  logic              ack_i,
    input  logic [IDX_W-1:0]  ack_idx_i,
    output logic              irq_o,
    output logic [IDX_W-1:0]  irq_idx_o
);
    localparam int SENSE_W  = 2 * (NUM_LINES - 1);
    localparam int BANK_LSB = DATA_W - NUM_LINES;

    logic [SENSE_W-1:0]   sense_q;
    logic                 sel_q;
    logic [NUM_LINES-1:0] en_q;
    logic [NUM_LINES-1:0] flag_q;
    logic [NUM_LINES-1:0] flag_nxt;
    logic [NUM_LINES-1:0] pin_s;
    logic [NUM_LINES-1:0] hit;
    logic [NUM_LINES-1:0] low;
    logic [NUM_LINES-1:0] req;
    logic                 wr_flag;

    eirq_sync #(.W(NUM_LINES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .q_o   (pin_s)
    );

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            logic [1:0] cfg;
            if (g < NUM_LINES - 1) begin : g_cfg_dual
                assign cfg = sense_q[2*g+1:2*g];
            end else begin : g_cfg_edge
                assign cfg = {1'b1, sel_q};
            end

            eirq_detect #(.DUAL_SENSE(g < NUM_LINES - 1)) i_detect (
                .clk   (clk),
                .rst_n (rst_n),
                .lvl_i (pin_s[g]),
                .cfg_i (cfg),
                .hit_o (hit[g]),
                .low_o (low[g])
            );

            // R8: write-one clears, unless an edge lands in the same cycle
            a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_flag && bus_wdata[BANK_LSB+g] && !hit[g]) |=> !flag_q[g]);

            // R9: acknowledge clears the named line
            a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_i && ack_idx_i == IDX_W'(g) && !hit[g]) |=> !flag_q[g]);
        end
    endgenerate

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q <= '0;
            sel_q   <= 1'b0;
            en_q    <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(REG_SENSE)) sense_q <= bus_wdata[SENSE_W-1:0];
            if (bus_addr == ADDR_W'(REG_SEL))   sel_q   <= bus_wdata[0];
            if (bus_addr == ADDR_W'(REG_EN))    en_q    <= bus_wdata[DATA_W-1:BANK_LSB];
        end
    end

    // Pending flags: a set beats a clear in the same cycle
    assign wr_flag = bus_we && (bus_addr == ADDR_W'(REG_FLAG));

    always_comb begin
        for (int i = 0; i < NUM_LINES; i++) begin
            flag_nxt[i] = hit[i] |
                (flag_q[i] & ~((wr_flag & bus_wdata[BANK_LSB+i]) |
                               (ack_i & (ack_idx_i == IDX_W'(i)))));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_nxt;
    end

    // Request and priority
    assign req = en_q & (flag_q | low);

    eirq_prio #(.N(NUM_LINES), .IW(IDX_W)) i_prio (
        .req_i (req),
        .any_o (irq_o),
        .idx_o (irq_idx_o)
    );

    // Read port
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(REG_SENSE)) bus_rdata[SENSE_W-1:0] = sense_q;
        if (bus_addr == ADDR_W'(REG_SEL))   bus_rdata[0] = sel_q;
        if (bus_addr == ADDR_W'(REG_EN))    bus_rdata[DATA_W-1:BANK_LSB] = en_q;
        if (bus_addr == ADDR_W'(REG_FLAG))  bus_rdata[DATA_W-1:BANK_LSB] = flag_q;
    end

    // R4: a level-sensed line 0 never latches a flag
    a_r4_level_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_e'(sense_q[1:0]) == SNS_LOW) |=> !$rose(flag_q[0]));

    // R10: the reported index belongs to a requesting line
    a_r10_idx_requests: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> req[irq_idx_o]);

    // R10: no request means index 0
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> (req == '0 && irq_idx_o == '0));

    // R10: line 0 wins whenever it requests
    a_r10_line0_first: assert property (@(posedge clk) disable iff (!rst_n)
        req[0] |-> (irq_o && irq_idx_o == '0));
endmodule

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [2:0] pin_i = 3'b111;
    logic       ack_i = 1'b0;
    logic [1:0] ack_idx_i = '0;
    logic       irq_o;
    logic [1:0] irq_idx_o;

    int checks = 0;
    int errors = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    ext_irq_ctrl i_ext_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pin_i     (pin_i),
        .ack_i     (ack_i),
        .ack_idx_i (ack_idx_i),
        .irq_o     (irq_o),
        .irq_idx_o (irq_idx_o)
    );

    // {sense[3:0], sel, en[2:0], pins_before[2:0], pins_after[2:0], irq, idx[1:0], flags[2:0]}
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {4'b0000, 1'b0, 3'b111, 3'b111, 3'b110, 1'b1, 2'd0, 3'b000},
        {4'b1010, 1'b0, 3'b011, 3'b111, 3'b101, 1'b1, 2'd1, 3'b010},
        {4'b1111, 1'b0, 3'b011, 3'b000, 3'b011, 1'b1, 2'd0, 3'b011},
        {4'b0101, 1'b0, 3'b011, 3'b011, 3'b001, 1'b1, 2'd1, 3'b010},
        {4'b0101, 1'b0, 3'b011, 3'b000, 3'b001, 1'b1, 2'd0, 3'b001},
        {4'b0000, 1'b0, 3'b100, 3'b100, 3'b000, 1'b1, 2'd2, 3'b100},
        {4'b0000, 1'b1, 3'b100, 3'b000, 3'b100, 1'b1, 2'd2, 3'b100},
        {4'b1010, 1'b0, 3'b000, 3'b111, 3'b000, 1'b0, 2'd0, 3'b111},
        {4'b1111, 1'b1, 3'b111, 3'b111, 3'b000, 1'b0, 2'd0, 3'b000},
        {4'b1010, 1'b0, 3'b110, 3'b111, 3'b000, 1'b1, 2'd1, 3'b111}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pins(input logic [2:0] p);
        @(negedge clk);
        pin_i = p;
    endtask

    task automatic ack(input logic [1:0] idx);
        @(negedge clk);
        ack_i     = 1'b1;
        ack_idx_i = idx;
        @(posedge clk);
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cycles(3);

        // R1: reset state
        chk("R1 irq", {7'b0, irq_o}, 8'h00);
        for (int a = 0; a < 4; a++) begin
            rd(a[1:0], rv);
            chk("R1 register", rv, 8'h00);
        end

        // R2: register map readback
        wr(2'd0, 8'hFF); rd(2'd0, rv); chk("R2 sense", rv, 8'h0F);
        wr(2'd1, 8'hFF); rd(2'd1, rv); chk("R2 select", rv, 8'h01);
        wr(2'd2, 8'hFF); rd(2'd2, rv); chk("R2 enable", rv, 8'hE0);
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h00); wr(2'd3, 8'hE0);

        // Vector table covering R3, R4, R5, R6, R10
        for (int v = 0; v < NV; v++) begin
            set_pins(VEC[v][11:9]);
            cycles(4);
            wr(2'd0, {4'b0, VEC[v][19:16]});
            wr(2'd1, {7'b0, VEC[v][15]});
            wr(2'd2, {VEC[v][14:12], 5'b0});
            wr(2'd3, 8'hE0);
            set_pins(VEC[v][8:6]);
            cycles(4);
            chk("R3/R4/R5/R6/R10 vector irq", {7'b0, irq_o}, {7'b0, VEC[v][5]});
            chk("R10 vector index", {6'b0, irq_idx_o}, {6'b0, VEC[v][4:3]});
            rd(2'd3, rv);
            chk("R3/R4/R5/R6 vector flags", rv, {VEC[v][2:0], 5'b0});
        end

        // R7: latency through the synchronizer
        wr(2'd2, 8'h00); wr(2'd1, 8'h00); wr(2'd0, 8'h02);
        set_pins(3'b111); cycles(4);
        wr(2'd3, 8'hE0); wr(2'd2, 8'h20);
        @(negedge clk); pin_i = 3'b110;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R7 not before third edge", {7'b0, irq_o}, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R7 at third edge", {7'b0, irq_o}, 8'h01);

        // R9: acknowledge clears only the named line
        wr(2'd2, 8'h00); wr(2'd0, 8'h0A);
        set_pins(3'b111); cycles(4); wr(2'd3, 8'hE0);
        set_pins(3'b000); cycles(4);
        rd(2'd3, rv); chk("R9 all pending", rv, 8'hE0);
        ack(2'd1); rd(2'd3, rv); chk("R9 ack line 1", rv, 8'hA0);
        ack(2'd0); rd(2'd3, rv); chk("R9 ack line 0", rv, 8'h80);

        // R8: write-one clear, zeros ignored
        set_pins(3'b111); cycles(4); wr(2'd3, 8'hE0);
        set_pins(3'b000); cycles(4);
        wr(2'd3, 8'h00); rd(2'd3, rv); chk("R8 write zero", rv, 8'hE0);
        wr(2'd3, 8'h40); rd(2'd3, rv); chk("R8 clear line 1", rv, 8'hA0);
        wr(2'd3, 8'h1F); rd(2'd3, rv); chk("R8 other bits", rv, 8'hA0);

        // R11: select flip on a steady high pin sets line 2
        wr(2'd0, 8'h00); wr(2'd2, 8'h00); wr(2'd1, 8'h00);
        set_pins(3'b111); cycles(4); wr(2'd3, 8'hE0);
        rd(2'd3, rv); chk("R11 clean start", rv, 8'h00);
        wr(2'd1, 8'h01); cycles(1);
        rd(2'd3, rv); chk("R11 spurious flag", rv, 8'h80);
        chk("R11 masked no irq", {7'b0, irq_o}, 8'h00);
        wr(2'd3, 8'h80); wr(2'd2, 8'h80); cycles(1);
        chk("R11 cleared then enabled", {7'b0, irq_o}, 8'h00);

        // R4: level request drops when the pin returns high
        wr(2'd2, 8'h20);
        set_pins(3'b110); cycles(3);
        chk("R4 level active", {7'b0, irq_o}, 8'h01);
        set_pins(3'b111); cycles(3);
        chk("R4 level released", {7'b0, irq_o}, 8'h00);
        rd(2'd3, rv); chk("R4 no flag", rv, 8'h00);

        finish_run();
    end
endmodule